// File: doc/BRIEF.md
# Command Word Bus Controller

This block sits between a pair of first-word-fall-through FIFOs and a small addressed peripheral bus. It takes 16-bit command words from the inbound FIFO. The upper byte of each word selects an operation, and the lower byte names a peripheral port. Some operations are followed by a count word and data words. The controller carries out each operation on the bus and places any reply words into the outbound FIFO.

Six operations are supported. A zero word does nothing. A ping echoes the word back. A counted block write sends data words to a port. A counted block read collects words from a port. A ready poll reports whether a port is ready. A continuous stream keeps reading a port until the host sends another nonzero word. The inbound side is read with a pop strobe while the FIFO is not empty. The outbound side is written with a push strobe while the FIFO is not full. The bus side carries an address, write data with a write strobe, and read data with a ready flag and a read strobe. All read traffic moves at the pace set by the peripheral's ready flag and by free space in the outbound FIFO.

Top module: `cmd_bus_ctrl`

## Requirements
- R1: An all-zero command word is popped and discarded. It causes no outbound push and no bus strobe.
- R2: A word with opcode 0x01 in bits 15:8 (ping) is pushed outbound unchanged. For example, 0x0167 returns 0x0167.
- R3: A word with opcode 0x03 (write) is followed by a count word N and then by N data words. Each data word appears on `bus_wdata` with `bus_wstb` high for exactly the cycle it is popped, in arrival order. A count of zero ends the command with no strobe.
- R4: A word with opcode 0x02 (read) is followed by a count word N. The controller then performs N transfers, each in a cycle where `bus_rdy` is high. Each transfer pushes `bus_rdata` outbound with a one-cycle `bus_rstb`. A count of zero performs none.
- R5: A word with opcode 0x04 (poll) pushes one reply word. Its bits 15:8 are 0xFF if `bus_rdy` is high and 0x00 if not. Its bits 7:0 are the port address.
- R6: A word with opcode 0x05 (stream) transfers one word from the port in every cycle where `bus_rdy` is high and there is outbound space. Zero words arriving meanwhile are popped and ignored. The first nonzero word is popped and ends the stream with no further transfer, and the controller then answers later commands.
- R7: `in_pop` is never high while `in_empty` is high, and `out_push` is never high while `out_full` is high. Reads, pings and polls stall while the outbound FIFO is full and resume when it has space.
- R8: A word with any opcode other than 0x01 to 0x05 is popped and dropped with no push or strobe. The next command is decoded normally.
- R9: A synchronous active-low reset returns the controller to command decode with all strobes low, abandoning any burst in progress.
- R10: `bus_addr` equals bits 7:0 of the command word while that word is decoded, and holds that value for the rest of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_empty | input | 1 | Inbound FIFO has no word |
| in_data | input | 16 | Inbound FIFO head word |
| in_pop | output | 1 | Pop the inbound head word this cycle |
| out_full | input | 1 | Outbound FIFO cannot accept a word |
| out_data | output | 16 | Word to push outbound |
| out_push | output | 1 | Push `out_data` this cycle |
| bus_addr | output | 8 | Peripheral port address |
| bus_wdata | output | 16 | Write data to the addressed port |
| bus_wstb | output | 1 | Write strobe, one cycle per word |
| bus_rdata | input | 16 | Read data from the addressed port |
| bus_rdy | input | 1 | Addressed port has a word ready |
| bus_rstb | output | 1 | Read strobe, one cycle per word taken |

## Verification
The bench sweeps write and read bursts over counts from zero to six and over different addresses. A controller that mishandled a zero count would hang waiting for data, or would eat the next command as payload. Reads and streams run against a peripheral that is ready only in some cycles. A strobe given in a cycle where the peripheral is not ready, or where the outbound FIFO is full, would show up as a skipped or duplicated value in the arithmetic sequence the bench expects. Stream tests send a zero word mid-stream, which must not stop the stream, and then a stop word; after the stop no further words may appear and a ping must be answered. A reset that arrives while a read burst is stalled must leave no pending transfer behind.

// File: rtl/cbc_pkg.sv
// Shared types and opcode values for the command word bus controller.
// Assumes opcodes fit in the upper part of a command word.
package cbc_pkg;

    localparam logic [7:0] OP_PING   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h02;
    localparam logic [7:0] OP_WRITE  = 8'h03;
    localparam logic [7:0] OP_POLL   = 8'h04;
    localparam logic [7:0] OP_STREAM = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WCNT,
        ST_WDAT,
        ST_RCNT,
        ST_RDAT,
        ST_STRM
    } cbc_state_t;

    typedef enum logic [1:0] {
        RS_ECHO,
        RS_POLL,
        RS_RDAT
    } cbc_rsel_t;

endpackage

// File: rtl/cbc_counter.sv
// Burst word counter: loaded from a count word, decremented once per
// transferred word, flags the final word. Assumes the sequencer never
// decrements a zero count.
module cbc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Load has priority; otherwise count down on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - CW'(1);
    end

    assign last = (cnt_q == CW'(1));

    // R3/R4: a transfer is only counted while words remain in the burst.
    p_dec_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/cbc_reply.sv
// Outbound word selector: the echoed command, the poll reply, or the
// peripheral's read data. Purely combinational.
module cbc_reply
    import cbc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  cbc_rsel_t      sel,
    input  logic [DW-1:0]  in_data,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_rdy,
    input  logic [AW-1:0]  addr,
    output logic [DW-1:0]  out_data
);

    localparam int OPW = DW - AW;

    // Pick the reply source for the current push.
    always_comb begin
        unique case (sel)
            RS_ECHO: out_data = in_data;
            RS_POLL: out_data = {{OPW{bus_rdy}}, addr};
            default: out_data = bus_rdata;
        endcase
    end

endmodule

// File: rtl/cbc_fsm.sv
// Command sequencer: decodes the inbound head word, runs counted bursts,
// polls and streams, and raises pop/push/strobe signals. Assumes both
// FIFOs present their head word and flags combinationally (fall-through).
module cbc_fsm
    import cbc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_empty,
    input  logic [DW-1:0]  in_data,
    output logic           in_pop,
    input  logic           out_full,
    output logic           out_push,
    input  logic           bus_rdy,
    output logic           bus_wstb,
    output logic           bus_rstb,
    output logic [AW-1:0]  bus_addr,
    output logic           cnt_load,
    output logic           cnt_dec,
    input  logic           cnt_last,
    output cbc_rsel_t      rsel
);

    localparam int OPW = DW - AW;

    cbc_state_t     state_q, state_d;
    logic [AW-1:0]  addr_q;
    logic [OPW-1:0] op;
    logic           word_zero;
    logic           rd_go;

    assign op        = in_data[DW-1:AW];
    assign word_zero = (in_data == '0);
    assign rd_go     = bus_rdy && !out_full;

    // Next state and per-cycle handshake decisions.
    always_comb begin
        state_d  = state_q;
        in_pop   = 1'b0;
        out_push = 1'b0;
        bus_wstb = 1'b0;
        bus_rstb = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        rsel     = RS_ECHO;
        unique case (state_q)
            ST_IDLE: begin
                if (!in_empty) begin
                    if (op == OPW'(OP_PING)) begin
                        if (!out_full) begin
                            in_pop   = 1'b1;
                            out_push = 1'b1;
                        end
                    end else if (op == OPW'(OP_POLL)) begin
                        if (!out_full) begin
                            in_pop   = 1'b1;
                            out_push = 1'b1;
                            rsel     = RS_POLL;
                        end
                    end else begin
                        in_pop = 1'b1;
                        if (op == OPW'(OP_WRITE))
                            state_d = ST_WCNT;
                        else if (op == OPW'(OP_READ))
                            state_d = ST_RCNT;
                        else if (op == OPW'(OP_STREAM))
                            state_d = ST_STRM;
                    end
                end
            end
            ST_WCNT, ST_RCNT: begin
                if (!in_empty) begin
                    in_pop   = 1'b1;
                    cnt_load = 1'b1;
                    if (word_zero)
                        state_d = ST_IDLE;
                    else
                        state_d = (state_q == ST_WCNT) ? ST_WDAT : ST_RDAT;
                end
            end
            ST_WDAT: begin
                if (!in_empty) begin
                    in_pop   = 1'b1;
                    bus_wstb = 1'b1;
                    cnt_dec  = 1'b1;
                    if (cnt_last)
                        state_d = ST_IDLE;
                end
            end
            ST_RDAT: begin
                if (rd_go) begin
                    out_push = 1'b1;
                    bus_rstb = 1'b1;
                    cnt_dec  = 1'b1;
                    rsel     = RS_RDAT;
                    if (cnt_last)
                        state_d = ST_IDLE;
                end
            end
            ST_STRM: begin
                if (!in_empty && !word_zero) begin
                    in_pop  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    in_pop = !in_empty;
                    if (rd_go) begin
                        out_push = 1'b1;
                        bus_rstb = 1'b1;
                        rsel     = RS_RDAT;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Latch the port address from each decoded command word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (state_q == ST_IDLE && in_pop)
            addr_q <= in_data[AW-1:0];
    end

    assign bus_addr = (state_q == ST_IDLE) ? in_data[AW-1:0] : addr_q;

    // R7: FIFO handshakes respect the flags.
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> !in_empty);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> !out_full);
    // R4: a read strobe only accompanies a ready port and an accepted push.
    p_rstb_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rstb |-> (bus_rdy && out_push));
    // R3: every write strobe consumes an inbound word.
    p_wstb_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wstb |-> in_pop);
    // R10: the address holds across a command in progress.
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(bus_addr));
    // R6: a nonzero word during a stream returns to decode.
    p_stream_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRM && !in_empty && !word_zero) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/cmd_bus_ctrl.sv
// Command word bus controller top: joins the sequencer, the burst counter
// and the reply selector. Assumes fall-through FIFOs on both sides and an
// external bridge that routes bus_addr to one peripheral port.
module cmd_bus_ctrl
    import cbc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_empty,
    input  logic [DW-1:0]  in_data,
    output logic           in_pop,
    input  logic           out_full,
    output logic [DW-1:0]  out_data,
    output logic           out_push,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    output logic           bus_wstb,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_rdy,
    output logic           bus_rstb
);

    logic      cnt_load, cnt_dec, cnt_last;
    cbc_rsel_t rsel;

    cbc_fsm #(.DW(DW), .AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_empty (in_empty),
        .in_data  (in_data),
        .in_pop   (in_pop),
        .out_full (out_full),
        .out_push (out_push),
        .bus_rdy  (bus_rdy),
        .bus_wstb (bus_wstb),
        .bus_rstb (bus_rstb),
        .bus_addr (bus_addr),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .cnt_last (cnt_last),
        .rsel     (rsel)
    );

    cbc_counter #(.CW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (in_data),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    cbc_reply #(.DW(DW), .AW(AW)) u_reply (
        .sel       (rsel),
        .in_data   (in_data),
        .bus_rdata (bus_rdata),
        .bus_rdy   (bus_rdy),
        .addr      (bus_addr),
        .out_data  (out_data)
    );

    assign bus_wdata = in_data;

    // R9: strobes stay low in the cycle after a reset edge.
    p_reset_quiet_r9: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> !(bus_wstb || bus_rstb || (out_push && !in_pop)));

endmodule

// File: tb/sim_cmd_bus_ctrl.sv
module sim_cmd_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_empty, in_pop, out_full, out_push;
    logic [15:0] in_data, out_data, bus_wdata, bus_rdata;
    logic [7:0]  bus_addr;
    logic        bus_wstb, bus_rdy, bus_rstb;

    always #10 clk = ~clk;

    cmd_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_data(in_data),
        .in_pop(in_pop), .out_full(out_full), .out_data(out_data),
        .out_push(out_push), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wstb(bus_wstb), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .bus_rstb(bus_rstb)
    );

    // Inbound FIFO model (fall-through) and capture stores.
    logic [15:0] inq [0:255];
    logic [15:0] outq [0:511];
    logic [15:0] wq [0:255];
    logic [7:0]  waddr [0:255];
    int wp = 0, rp = 0, ow = 0, wn = 0, rn = 0, cyc = 0;
    int rdy_mode = 0;
    logic full_force = 1'b0;
    int total = 0, bad = 0, mon_bad = 0;

    assign in_empty  = (rp == wp);
    assign in_data   = inq[rp % 256];
    assign out_full  = full_force;
    assign bus_rdata = 16'hBEE0 + rn[15:0];
    assign bus_rdy   = (rdy_mode == 1) || (rdy_mode == 2 && (cyc % 5) < 3);

    // Models of the FIFOs and the peripheral, updated at the clock edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_pop) rp <= rp + 1;
        if (out_push) begin
            outq[ow % 512] <= out_data;
            ow <= ow + 1;
        end
        if (bus_wstb) begin
            wq[wn % 256]    <= bus_wdata;
            waddr[wn % 256] <= bus_addr;
            wn <= wn + 1;
        end
        if (bus_rstb) rn <= rn + 1;
        if (rst_n && ((bus_rstb && !bus_rdy) || (in_pop && in_empty) || (out_push && out_full))) begin
            mon_bad <= mon_bad + 1;
            $display("FAIL R7 handshake violation: rstb=%0b rdy=%0b pop=%0b empty=%0b push=%0b full=%0b (expected none)",
                     bus_rstb, bus_rdy, in_pop, in_empty, out_push, out_full);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        @(negedge clk);
        inq[wp % 256] = w;
        wp = wp + 1;
    endtask

    task automatic settle(input int n);
        for (int t = 0; t < 2000 && rp != wp; t++) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_out(input int target);
        for (int t = 0; t < 5000 && ow < target; t++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total + 1, bad + mon_bad + 1);
        $finish;
    end

    initial begin
        int ow0, rn0, wn0, n;
        // R9: reset state
        repeat (3) @(negedge clk);
        check(!in_pop && !out_push && !bus_wstb && !bus_rstb, "R9 strobes in reset", 
              {in_pop, out_push, bus_wstb, bus_rstb}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!in_pop && !out_push && !bus_wstb && !bus_rstb, "R9 idle after reset",
              {in_pop, out_push, bus_wstb, bus_rstb}, 0);

        // R1: zero word discarded
        ow0 = ow;
        put(16'h0000);
        settle(4);
        check(rp == wp, "R1 zero word consumed", rp, wp);
        check(ow == ow0 && wn == 0 && rn == 0, "R1 no effect", ow - ow0 + wn + rn, 0);

        // R2: ping echo sweep
        ow0 = ow;
        for (int i = 0; i < 10; i++) put(16'h0167 + 16'(i));
        settle(3);
        check(ow - ow0 == 10, "R2 ping count", ow - ow0, 10);
        for (int i = 0; i < 10; i++)
            check(outq[(ow0 + i) % 512] == 16'h0167 + 16'(i), "R2 ping echo",
                  outq[(ow0 + i) % 512], 16'h0167 + i);

        // R8: unknown opcodes dropped
        ow0 = ow;
        put(16'h07AB); put(16'hFF12); put(16'h0034);
        settle(4);
        check(rp == wp && ow == ow0 && wn == 0 && rn == 0, "R8 unknown dropped", ow - ow0, 0);
        put(16'h01C3);
        settle(3);
        check(outq[(ow - 1) % 512] == 16'h01C3, "R8 decode after drop", outq[(ow - 1) % 512], 16'h01C3);

        // R3/R10: write bursts N = 0..6
        for (int nb = 0; nb <= 6; nb++) begin
            wn0 = wn;
            put(16'h0310 + 16'(nb));
            put(16'(nb));
            for (int k = 0; k < nb; k++) put(16'h7870 + 16'(k));
            settle(3);
            check(wn - wn0 == nb, "R3 write strobe count", wn - wn0, nb);
            for (int k = 0; k < nb; k++) begin
                check(wq[(wn0 + k) % 256] == 16'h7870 + 16'(k), "R3 write data order",
                      wq[(wn0 + k) % 256], 16'h7870 + k);
                check(waddr[(wn0 + k) % 256] == 8'h10 + 8'(nb), "R10 write address",
                      waddr[(wn0 + k) % 256], 8'h10 + nb);
            end
        end
        put(16'h0155);
        settle(3);
        check(outq[(ow - 1) % 512] == 16'h0155, "R3 ping after zero-count write",
              outq[(ow - 1) % 512], 16'h0155);

        // R4: read bursts N = 0..6 with a gappy peripheral
        rdy_mode = 2;
        for (int nb = 0; nb <= 6; nb++) begin
            ow0 = ow; rn0 = rn;
            put(16'h0201);
            put(16'(nb));
            settle(0);
            wait_out(ow0 + nb);
            repeat (5) @(negedge clk);
            check(ow - ow0 == nb && rn - rn0 == nb, "R4 read count", ow - ow0, nb);
            for (int k = 0; k < nb; k++)
                check(outq[(ow0 + k) % 512] == 16'hBEE0 + 16'(rn0 + k), "R4 read data order",
                      outq[(ow0 + k) % 512], 16'hBEE0 + ((rn0 + k) & 16'hFFFF));
        end

        // R7: read stalls on a full outbound FIFO
        rdy_mode = 1;
        full_force = 1'b1;
        ow0 = ow; rn0 = rn;
        put(16'h0202); put(16'h0003);
        settle(20);
        check(ow == ow0 && rn == rn0, "R7 read stalled while full", rn - rn0, 0);
        @(negedge clk); full_force = 1'b0;
        wait_out(ow0 + 3);
        repeat (4) @(negedge clk);
        check(ow - ow0 == 3, "R7 read resumes", ow - ow0, 3);
        check(outq[(ow0 + 2) % 512] == 16'hBEE0 + 16'(rn0 + 2), "R7 data after stall",
              outq[(ow0 + 2) % 512], 16'hBEE0 + ((rn0 + 2) & 16'hFFFF));
        full_force = 1'b1;
        ow0 = ow;
        put(16'h01AA);
        repeat (10) @(negedge clk);
        check(rp != wp && ow == ow0, "R7 ping held while full", ow - ow0, 0);
        full_force = 1'b0;
        settle(3);
        check(ow - ow0 == 1 && outq[ow0 % 512] == 16'h01AA, "R7 ping after space",
              outq[ow0 % 512], 16'h01AA);

        // R5: poll ready and not ready
        rdy_mode = 1;
        put(16'h0401);
        settle(3);
        check(outq[(ow - 1) % 512] == 16'hFF01, "R5 poll ready", outq[(ow - 1) % 512], 16'hFF01);
        rdy_mode = 0;
        put(16'h0423);
        settle(3);
        check(outq[(ow - 1) % 512] == 16'h0023, "R5 poll not ready", outq[(ow - 1) % 512], 16'h0023);

        // R9: reset abandons a stalled read burst
        rn0 = rn;
        put(16'h0203); put(16'h0005);
        settle(5);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rdy_mode = 1;
        repeat (10) @(negedge clk);
        check(rn == rn0, "R9 burst abandoned by reset", rn - rn0, 0);
        put(16'h0177);
        settle(3);
        check(outq[(ow - 1) % 512] == 16'h0177, "R9 ping after reset", outq[(ow - 1) % 512], 16'h0177);

        // R6: stream with a zero word mid-stream, then a stop word
        rdy_mode = 2;
        ow0 = ow; rn0 = rn;
        put(16'h0501);
        wait_out(ow0 + 10);
        put(16'h0000);
        wait_out(ow0 + 30);
        check(rp == wp && ow - ow0 >= 30, "R6 zero word ignored in stream", ow - ow0, 30);
        put(16'h0501);
        settle(3);
        n = ow - ow0;
        repeat (20) @(negedge clk);
        check(ow - ow0 == n, "R6 stream stopped", ow - ow0, n);
        check(rn - rn0 == n, "R6 strobes match pushes", rn - rn0, n);
        for (int k = 0; k < n; k++)
            check(outq[(ow0 + k) % 512] == 16'hBEE0 + 16'(rn0 + k), "R6 stream data order",
                  outq[(ow0 + k) % 512], 16'hBEE0 + ((rn0 + k) & 16'hFFFF));
        put(16'h01FF);
        settle(3);
        check(ow - ow0 == n + 1 && outq[(ow - 1) % 512] == 16'h01FF, "R6 ping after stream",
              outq[(ow - 1) % 512], 16'h01FF);

        check(mon_bad == 0, "R7 handshake monitor", mon_bad, 0);
        $display("  test done: total=%0d bad=%0d", total, bad + mon_bad);
        $finish;
    end

endmodule